// File: doc/BRIEF.md
# Pipelined-Adder Transposed FIR Low-Pass Filter

This block is a four-tap low-pass FIR filter in transposed form. It takes one signed 16-bit sample on every clock and returns one filtered sample on every clock. There is no stall and no handshake. Each tap multiplies the sample by a fixed coefficient, adds the product to the partial sum from the tap further up the chain, and passes the result toward the output.

Every partial-sum adder is a pipelined unit with several register stages. Each hop along the chain therefore costs the adder latency instead of one sample. The block does not stretch the chain delays, because that would put zero-valued taps into the impulse response. Instead it holds back the input sample at each tap by a skew that grows toward the output end. Every coefficient path then gains the same extra delay, and adjacent taps stay exactly one sample apart. The output is the ideal filter response shifted by a constant latency, which is published as the `LATENCY` parameter. A valid flag rises once the pipeline has filled.

Top module: `fir_transposed_pipe`

## Requirements
- R1: One new sample on `x_in` is accepted on every rising clock edge while reset is low, with no stall input, and every sample contributes to the output.
- R2: The coefficient word for tap k occupies bits 16k+15 down to 16k of `COEFS` (default b0..b3 = 3932, 12452, 11796, 4588). The `y_out` visible after the edge that samples x[n]+LATENCY edges equals b0·x[n]+b1·x[n-1]+b2·x[n-2]+b3·x[n-3], with samples before reset counting as zero.
- R3: LATENCY equals (L-1)(N-1)+L, where L is the adder latency and N is the tap count, which gives 9 for the defaults. An impulse of amplitude A yields A·b0, A·b1, A·b2 and A·b3 on four consecutive cycles starting LATENCY edges after the impulse, with no zero gap between them, and zero elsewhere.
- R4: The result is carried at full precision in 34 signed bits with no wrap or saturation. Its magnitude never exceeds 32768 times the sum of the coefficient magnitudes, including for inputs at -32768 and 32767.
- R5: A synchronous active-high reset clears all skew, product and adder registers. After any reset edge, `y_out` is 0 and `y_valid` is 0.
- R6: `y_valid` is 0 for the first LATENCY edges after reset is released, becomes 1 after edge number LATENCY+1, and stays 1 until the next reset.
- R7: A constant input c held for at least LATENCY+N samples gives `y_out` = c·32768, because the default coefficients sum to 32768.
- R8: A reset in the middle of a stream discards all earlier samples, so the output afterwards depends only on the samples taken after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | Signed two's-complement input sample, one per clock |
| y_out | output | 34 | Signed full-precision filtered sample |
| y_valid | output | 1 | High once the pipeline has filled after reset |

## Verification
A single impulse isolates each coefficient in its own output cycle. This exposes a swapped coefficient, a wrong skew depth, or a stretched chain delay that would open zero gaps. A held step checks that all four paths add up to the exact DC gain. A reversal of the step sign shows whether the transition passes through the taps in the right order. Random samples, extreme alternating full-scale values and a reset in mid-stream separate a correct full-width datapath from one that truncates, wraps or keeps old history.

// File: rtl/fir_pkg.sv
package fir_pkg;

    localparam int SAMPLE_W    = 16;
    localparam int COEF_W      = 16;
    localparam int DEF_TAPS    = 4;
    localparam int DEF_ADD_LAT = 3;
    localparam int GUARD_W     = $clog2(DEF_TAPS);
    localparam int ACC_W       = SAMPLE_W + COEF_W + GUARD_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [ACC_W-1:0]    acc_t;

    // Operands presented to one tap: skewed sample and upstream partial sum
    typedef struct packed {
        sample_t x;
        acc_t    psum;
    } tap_in_t;

    // Low-pass default, tap 0 in the least significant word; sums to 32768
    localparam logic [DEF_TAPS*COEF_W-1:0] DEF_COEFS =
        {16'd4588, 16'd11796, 16'd12452, 16'd3932};

    // Constant delay from a sample edge to its filtered result
    function automatic int pipe_latency(input int taps, input int add_lat);
        return (add_lat - 1) * (taps - 1) + add_lat;
    endfunction

    // Extra sample delay for tap k (k = 0 at the output end)
    function automatic int skew_depth(input int taps, input int add_lat, input int k);
        return (add_lat - 1) * (taps - 1 - k);
    endfunction

endpackage

// File: rtl/fir_skew_line.sv
module fir_skew_line
    import fir_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t din,
    output sample_t dout
);

    sample_t sr_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) sr_q[i] <= '0;
        end else begin
            sr_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) sr_q[i] <= sr_q[i-1];
        end
    end

    assign dout = sr_q[DEPTH-1];

endmodule

// File: rtl/fir_pipe_adder.sv
module fir_pipe_adder
    import fir_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  acc_t op_a,
    input  acc_t op_b,
    output acc_t sum
);

    acc_t stg_q [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LAT; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= op_a + op_b;
            for (int i = 1; i < LAT; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sum = stg_q[LAT-1];

endmodule

// File: rtl/fir_tap.sv
module fir_tap
    import fir_pkg::*;
#(
    parameter int    SKEW = 0,
    parameter int    LAT  = 3,
    parameter coef_t COEF = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t x_in,
    input  acc_t    psum_in,
    output acc_t    psum_out
);

    tap_in_t ops;
    acc_t    prod_q;

    generate
        if (SKEW == 0) begin : g_direct
            assign ops.x = x_in;
        end else begin : g_skew
            fir_skew_line #(.DEPTH(SKEW)) u_skew (
                .clk  (clk),
                .rst  (rst),
                .din  (x_in),
                .dout (ops.x)
            );
        end
    endgenerate

    assign ops.psum = psum_in;

    // Product register: equal delay on every tap, so it shifts no alignment
    always_ff @(posedge clk) begin
        if (rst) prod_q <= '0;
        else     prod_q <= acc_t'(ops.x) * acc_t'(COEF);
    end

    fir_pipe_adder #(.LAT(LAT)) u_add (
        .clk  (clk),
        .rst  (rst),
        .op_a (prod_q),
        .op_b (ops.psum),
        .sum  (psum_out)
    );

endmodule

// File: rtl/fir_transposed_pipe.sv
module fir_transposed_pipe
    import fir_pkg::*;
#(
    parameter int                         N_TAPS  = DEF_TAPS,
    parameter int                         ADD_LAT = DEF_ADD_LAT,
    parameter logic [N_TAPS*COEF_W-1:0]   COEFS   = DEF_COEFS
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic signed [SAMPLE_W-1:0] x_in,
    output logic signed [ACC_W-1:0]    y_out,
    output logic                       y_valid
);

    localparam int LATENCY = pipe_latency(N_TAPS, ADD_LAT);
    localparam int CNT_W   = $clog2(LATENCY + 1);

    acc_t chain [N_TAPS+1];

    assign chain[N_TAPS] = '0;

    generate
        for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
            fir_tap #(
                .SKEW (skew_depth(N_TAPS, ADD_LAT, k)),
                .LAT  (ADD_LAT),
                .COEF (coef_t'(COEFS[k*COEF_W +: COEF_W]))
            ) u_tap (
                .clk      (clk),
                .rst      (rst),
                .x_in     (x_in),
                .psum_in  (chain[k+1]),
                .psum_out (chain[k])
            );
        end
    endgenerate

    assign y_out = chain[0];

    logic [CNT_W-1:0] fill_q;
    logic             valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (fill_q != CNT_W'(LATENCY)) fill_q <= fill_q + 1'b1;
            valid_q <= (fill_q == CNT_W'(LATENCY));
        end
    end

    assign y_valid = valid_q;

endmodule

// File: rtl/fir_transposed_pipe_chk.sv
module fir_transposed_pipe_chk
    import fir_pkg::*;
#(
    parameter int                       N_TAPS  = DEF_TAPS,
    parameter int                       LATENCY = 9,
    parameter logic [N_TAPS*COEF_W-1:0] COEFS   = DEF_COEFS
) (
    input logic                       clk,
    input logic                       rst,
    input logic signed [SAMPLE_W-1:0] x_in,
    input logic signed [ACC_W-1:0]    y_out,
    input logic                       y_valid
);

    function automatic longint coef_sum(input bit magnitude);
        longint s = 0;
        for (int k = 0; k < N_TAPS; k++) begin
            longint c = longint'($signed(COEFS[k*COEF_W +: COEF_W]));
            s += (magnitude && c < 0) ? -c : c;
        end
        return s;
    endfunction

    localparam longint SUM_B   = coef_sum(1'b0);
    localparam longint Y_LIMIT = 32768 * coef_sum(1'b1);
    localparam int     RUN_MAX = LATENCY + N_TAPS;

    int                         seen;
    int                         run;
    logic signed [SAMPLE_W-1:0] last_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen   <= 0;
            run    <= 0;
            last_x <= '0;
        end else begin
            if (seen <= LATENCY) seen <= seen + 1;
            last_x <= x_in;
            if (run == 0 || x_in != last_x) run <= 1;
            else if (run < RUN_MAX)         run <= run + 1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (y_out == '0 && !y_valid)); // R5

    AST_VALID_FILL: assert property (@(posedge clk) disable iff (rst)
        y_valid == (seen > LATENCY)); // R6

    AST_STEP_SETTLE: assert property (@(posedge clk) disable iff (rst)
        (run >= RUN_MAX) |-> (longint'(y_out) == longint'(last_x) * SUM_B)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (longint'(y_out) <= Y_LIMIT && longint'(y_out) >= -Y_LIMIT)); // R4

endmodule

bind fir_transposed_pipe fir_transposed_pipe_chk #(
    .N_TAPS  (N_TAPS),
    .LATENCY (LATENCY),
    .COEFS   (COEFS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .x_in    (x_in),
    .y_out   (y_out),
    .y_valid (y_valid)
);

// File: tb/fir_transposed_pipe_test.sv
module fir_transposed_pipe_test;

    localparam int LAT_EXP = 9;   // (3-1)*(4-1)+3
    localparam longint B0 = 3932, B1 = 12452, B2 = 11796, B3 = 4588;

    typedef struct {
        longint y;
        string  tag;
    } exp_t;

    logic               clk;
    logic               rst;
    logic signed [15:0] x_in;
    logic signed [33:0] y_out;
    logic               y_valid;

    exp_t   sbq[$];
    longint hist[4];
    int     edges;
    bit     seen_rst;
    bit     done;
    int     n_checks;
    int     n_fail;

    fir_transposed_pipe uut (
        .clk     (clk),
        .rst     (rst),
        .x_in    (x_in),
        .y_out   (y_out),
        .y_valid (y_valid)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    initial begin
        edges    = 0;
        seen_rst = 1'b0;
        done     = 1'b0;
        n_checks = 0;
        n_fail   = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            edges    <= 0;
            seen_rst <= 1'b1;
        end else begin
            edges <= edges + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Driver: called at a falling edge, presents a sample and queues its result
    task automatic drive(input longint x, input string tag);
        exp_t e;
        x_in = 16'(x);
        for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(16'(x)));
        e.y   = B0 * hist[0] + B1 * hist[1] + B2 * hist[2] + B3 * hist[3];
        e.tag = tag;
        sbq.push_back(e);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst  = 1'b1;
        x_in = '0;
        repeat (3) @(negedge clk);
        sbq.delete();
        for (int k = 0; k < 4; k++) hist[k] = 0;
        rst = 1'b0;
    endtask

    // Monitor: compares outputs half a cycle after each rising edge
    always @(negedge clk) begin
        if (seen_rst && !done) begin
            if (edges == 0) begin
                check(y_out == 0, "R5", "y_out in reset", longint'(y_out), 0);
                check(!y_valid, "R5", "y_valid in reset", longint'(y_valid), 0);
            end else begin
                check(y_valid == (edges > LAT_EXP), "R6", "y_valid",
                      longint'(y_valid), longint'(edges > LAT_EXP));
                if (edges > LAT_EXP) begin
                    if (sbq.size() == 0) begin
                        check(1'b0, "R1", "scoreboard empty", 0, 1);
                    end else begin
                        exp_t e;
                        e = sbq.pop_front();
                        check(longint'(y_out) == e.y, e.tag, "y_out",
                              longint'(y_out), e.y);
                    end
                end else begin
                    check(y_out == 0, "R6", "y_out before fill", longint'(y_out), 0);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        do_reset();

        // R3: impulse exposes tap order, latency and absence of gaps
        drive(1000, "R3");
        repeat (14) drive(0, "R3");

        // R4: full-scale negative impulse
        drive(-32768, "R4");
        repeat (6) drive(0, "R4");

        // R7: held step settles to c*32768, then a sign reversal
        repeat (20) drive(20000, "R7");
        repeat (20) drive(-7, "R7");

        // R1, R2: random samples back to back, one per clock
        repeat (300) begin
            r = 16'($urandom);
            drive(longint'($signed(r)), "R2");
        end

        // R4: alternating extremes, then a held minimum
        repeat (16) begin
            drive(32767, "R4");
            drive(-32768, "R4");
        end
        repeat (16) drive(-32768, "R4");

        // R8: reset in mid-stream drops the earlier history
        repeat (5) begin
            r = 16'($urandom);
            drive(longint'($signed(r)), "R8");
        end
        do_reset();
        drive(500, "R8");
        repeat (12) drive(0, "R8");
        repeat (LAT_EXP + 2) drive(0, "R2");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule